// File: doc/BRIEF.md
# Five-Level Phase Switch-State Selector

This block drives the four switch pairs of one phase leg of a five-level inverter fed from a single DC link. It uses two floating capacitors, C1 and C2. A modulator asks for an output level from 0 to 4. The block turns that level into a 4-bit switch vector.

Levels 1, 2 and 3 can each be made by more than one vector. Each of those vectors moves the two capacitors in its own way. The block picks the vector that best pulls each capacitor back toward its hysteresis band, taking the direction of the load current into account.

The chosen vector is captured on a sample strobe. Each switch pair then gets a high-side and low-side gate command. A programmable dead time is inserted wherever a pair changes state.

Top module: `lsp_phase_top`

## Requirements
- R1: During and after reset, the stored vector is 0000, every `gate_hi` bit is 0 and every `gate_lo` bit is 1.
- R2: Level 0 always selects 0000 and level 4 always selects 1111, whatever the flags. Vector digits are written s1 s2 s3 s4, with s1 driving pair 3 (`gate_hi[3]`) and s4 driving pair 0.
- R3: Level 1 candidates, in priority order, are 0001, 0110 and 1010. With `i_neg`=0 their effects are as follows. 0001 leaves C1 alone and drains C2. 0110 drains C1 and charges C2. 1010 charges both.
- R4: Level 2 candidates, in order, are 1000 and 0100. With `i_neg`=0, 1000 charges C1 and 0100 drains C1. Neither touches C2.
- R5: Level 3 candidates, in order, are 0101, 1001 and 1110. With `i_neg`=0 their effects are as follows. 0101 drains both capacitors. 1001 charges C1 and drains C2. 1110 leaves C1 alone and charges C2.
- R6: With `i_neg`=1, every charge effect is treated as a drain and every drain as a charge before scoring.
- R7: Each capacitor flag uses this encoding: 00 means in band, 01 means too low, 10 means too high, and 11 is treated as in band. A candidate scores +1 for each capacitor it moves toward the band and -1 for each it moves away. The highest score wins, and ties go to the earliest candidate in the listed order.
- R8: If the stored vector is a candidate for the requested level and ties for the best score, it is kept.
- R9: A capacitor whose enable is 0, or whose flag is in band, adds nothing to any score.
- R10: The stored vector changes only on a cycle with `smp`=1. Inputs changed without a strobe leave the gates as they were.
- R11: When a pair's stored bit changes, the old gate value holds through the next cycle. Both `gate_hi` and `gate_lo` of that pair are then 0 for exactly DEAD_CYC cycles, after which the new value appears.
- R12: A strobe with a requested level of 5, 6 or 7 leaves the stored vector unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp | input | 1 | Sample strobe that stores a new vector |
| lvl_req | input | 3 | Requested level, 0 to 4 |
| i_neg | input | 1 | 1 when the load current is negative |
| c1_flag | input | 2 | C1 hysteresis flag (00 band, 01 low, 10 high, 11 band) |
| c2_flag | input | 2 | C2 hysteresis flag, same encoding |
| c1_bal_en | input | 1 | Enables balancing of C1 |
| c2_bal_en | input | 1 | Enables balancing of C2 |
| gate_hi | output | 4 | Upper-switch command per pair |
| gate_lo | output | 4 | Complementary switch command per pair |

## Verification
The embedded assertions run on every cycle and cover several properties:
- every strobe of a legal level stores a vector that produces exactly that level;
- the vector never moves without a strobe, and an illegal level never moves it;
- neither gate of a pair rises unless its partner was low in the cycle before.

Which redundant vector gets chosen is something only the bench's scenarios can show. That covers the scoring, the current-direction inversion, the enables, the tie-breaking and the keep-current rule. The bench also measures the exact length of the dead-time window.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

   localparam int SW_N     = 4;
   localparam int CAND_MAX = 3;

   typedef logic [SW_N-1:0] sw_vec_t;
   typedef logic signed [1:0] eff_t;
   typedef logic signed [2:0] score_t;

   typedef enum logic [1:0] {
      FLG_BAND  = 2'b00,
      FLG_LOW   = 2'b01,
      FLG_HIGH  = 2'b10,
      FLG_BAND2 = 2'b11
   } cap_flag_e;

   typedef struct packed {
      logic [1:0]             n;
      sw_vec_t [CAND_MAX-1:0] c;
   } cand_set_t;

   function automatic cand_set_t cand_of(input logic [2:0] lvl);
      cand_set_t r;
      r = '0;
      case (lvl)
         3'd0: begin r.n = 2'd1; r.c[0] = 4'b0000; end
         3'd1: begin r.n = 2'd3; r.c[0] = 4'b0001; r.c[1] = 4'b0110; r.c[2] = 4'b1010; end
         3'd2: begin r.n = 2'd2; r.c[0] = 4'b1000; r.c[1] = 4'b0100; end
         3'd3: begin r.n = 2'd3; r.c[0] = 4'b0101; r.c[1] = 4'b1001; r.c[2] = 4'b1110; end
         3'd4: begin r.n = 2'd1; r.c[0] = 4'b1111; end
         default: r.n = 2'd0;
      endcase
      return r;
   endfunction

   // effect on C1 for positive current: +1 charge, -1 drain, 0 none
   function automatic eff_t c1_eff(input sw_vec_t s);
      case (s)
         4'b1010, 4'b1000, 4'b1001: return 2'sb01;
         4'b0110, 4'b0100, 4'b0101: return 2'sb11;
         default:                   return 2'sb00;
      endcase
   endfunction

   function automatic eff_t c2_eff(input sw_vec_t s);
      case (s)
         4'b0110, 4'b1010, 4'b1110: return 2'sb01;
         4'b0001, 4'b0101, 4'b1001: return 2'sb11;
         default:                   return 2'sb00;
      endcase
   endfunction

   function automatic eff_t contrib(input eff_t e, input logic [1:0] flg,
                                    input logic en, input logic neg);
      eff_t d;
      d = neg ? -e : e;
      if (!en) return 2'sb00;
      case (cap_flag_e'(flg))
         FLG_LOW:  return d;
         FLG_HIGH: return -d;
         default:  return 2'sb00;
      endcase
   endfunction

   // level produced by a vector, used only by checks
   function automatic logic [2:0] lvl_of(input sw_vec_t s);
      case (s)
         4'b0000:                   return 3'd0;
         4'b0001, 4'b0110, 4'b1010: return 3'd1;
         4'b1000, 4'b0100:          return 3'd2;
         4'b0101, 4'b1001, 4'b1110: return 3'd3;
         4'b1111:                   return 3'd4;
         default:                   return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/lsp_pick.sv
module lsp_pick
   import lsp_pkg::*;
(
   input  logic [2:0] lvl_req,
   input  logic       i_neg,
   input  logic [1:0] c1_flag,
   input  logic [1:0] c2_flag,
   input  logic       c1_bal_en,
   input  logic       c2_bal_en,
   input  sw_vec_t    cur,
   output sw_vec_t    nxt,
   output logic       lvl_ok
);

   cand_set_t cs;
   score_t    sc [CAND_MAX];

   assign cs     = cand_of(lvl_req);
   assign lvl_ok = (cs.n != 2'd0);

   for (genvar k = 0; k < CAND_MAX; k++) begin : g_score
      eff_t p1, p2;
      assign p1    = contrib(c1_eff(cs.c[k]), c1_flag, c1_bal_en, i_neg);
      assign p2    = contrib(c2_eff(cs.c[k]), c2_flag, c2_bal_en, i_neg);
      assign sc[k] = $signed({p1[1], p1}) + $signed({p2[1], p2});
   end

   logic [1:0] best_i;
   score_t     best_s;
   logic       keep;

   always_comb begin
      best_i = 2'd0;
      best_s = sc[0];
      for (int i = 1; i < CAND_MAX; i++) begin
         if (2'(i) < cs.n && sc[i] > best_s) begin
            best_i = 2'(i);
            best_s = sc[i];
         end
      end
      keep = 1'b0;
      for (int i = 0; i < CAND_MAX; i++) begin
         if (2'(i) < cs.n && cs.c[i] == cur && sc[i] == best_s) keep = 1'b1;
      end
      nxt = keep ? cur : cs.c[best_i];
   end

endmodule

// File: rtl/lsp_deadband.sv
module lsp_deadband #(
   parameter int DEAD_CYC = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgt,
   output logic g_hi,
   output logic g_lo
);

   localparam int CW = $clog2(DEAD_CYC + 1);

   logic          applied;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         applied <= 1'b0;
         cnt     <= '0;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else if (tgt != applied) begin
         applied <= tgt;
         cnt     <= CW'(DEAD_CYC);
      end
   end

   assign g_hi = (cnt == '0) &  applied;
   assign g_lo = (cnt == '0) & ~applied;

   // R11: a gate only turns on after a cycle with its partner off
   a_r11_hi_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(g_hi) |-> $past(!g_lo));
   a_r11_lo_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(g_lo) |-> $past(!g_hi));

endmodule

// File: rtl/lsp_phase_top.sv
module lsp_phase_top
   import lsp_pkg::*;
#(
   parameter int DEAD_CYC = 300
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp,
   input  logic [2:0] lvl_req,
   input  logic       i_neg,
   input  logic [1:0] c1_flag,
   input  logic [1:0] c2_flag,
   input  logic       c1_bal_en,
   input  logic       c2_bal_en,
   output logic [3:0] gate_hi,
   output logic [3:0] gate_lo
);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end

   sw_vec_t state_q, nxt;
   logic    lvl_ok;

   lsp_pick u_pick (
      .lvl_req   (lvl_req),
      .i_neg     (i_neg),
      .c1_flag   (c1_flag),
      .c2_flag   (c2_flag),
      .c1_bal_en (c1_bal_en),
      .c2_bal_en (c2_bal_en),
      .cur       (state_q),
      .nxt       (nxt),
      .lvl_ok    (lvl_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)              state_q <= '0;
      else if (smp && lvl_ok)  state_q <= nxt;
   end

   for (genvar p = 0; p < SW_N; p++) begin : g_pair
      lsp_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
         .clk   (clk),
         .rst_n (rst_n),
         .tgt   (state_q[p]),
         .g_hi  (gate_hi[p]),
         .g_lo  (gate_lo[p])
      );
   end

   // R2, R3, R4, R5: stored vector produces the requested level
   a_r2_level_match: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && lvl_req <= 3'd4) |=> (lvl_of(state_q) == $past(lvl_req)));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !smp |=> $stable(state_q));
   a_r12_bad_level: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && lvl_req > 3'd4) |=> $stable(state_q));

endmodule

// File: tb/lsp_phase_top_bench.sv
module lsp_phase_top_bench;

   localparam int DEAD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp = 1'b0;
   logic [2:0] lvl_req = 3'd0;
   logic       i_neg = 1'b0;
   logic [1:0] c1_flag = 2'b00, c2_flag = 2'b00;
   logic       c1_bal_en = 1'b1, c2_bal_en = 1'b1;
   logic [3:0] gate_hi, gate_lo;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   typedef struct { logic [3:0] st; string tag; } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   lsp_phase_top #(.DEAD_CYC(DEAD)) u_lsp_phase_top (
      .clk(clk), .rst_n(rst_n), .smp(smp), .lvl_req(lvl_req), .i_neg(i_neg),
      .c1_flag(c1_flag), .c2_flag(c2_flag), .c1_bal_en(c1_bal_en),
      .c2_bal_en(c2_bal_en), .gate_hi(gate_hi), .gate_lo(gate_lo));

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] lv, input logic ng, input logic [1:0] f1,
                        input logic [1:0] f2, input logic e1, input logic e2,
                        input logic stb, input logic [3:0] exp, input string tag);
      exp_t it;
      @(negedge clk);
      lvl_req = lv; i_neg = ng; c1_flag = f1; c2_flag = f2;
      c1_bal_en = e1; c2_bal_en = e2; smp = stb;
      @(posedge clk);
      @(negedge clk);
      smp = 1'b0;
      it.st = exp; it.tag = tag;
      q.push_back(it);
      repeat (DEAD + 3) @(negedge clk);
   endtask

   // monitor: pops each expected vector once the dead window has passed
   initial begin
      forever begin
         exp_t it;
         wait (q.size() != 0);
         repeat (DEAD + 1) @(negedge clk);
         it = q.pop_front();
         check({it.tag, " hi"}, gate_hi, it.st);
         check({it.tag, " lo"}, gate_lo, ~it.st);
      end
   end

   task automatic dead_probe;
      @(negedge clk);
      lvl_req = 3'd4; smp = 1'b1;
      @(posedge clk);
      @(negedge clk);
      smp = 1'b0;
      check("R11 old value held hi", gate_hi, 4'b0000);
      check("R11 old value held lo", gate_lo, 4'b1111);
      @(negedge clk);
      check("R11 dead start hi", gate_hi, 4'b0000);
      check("R11 dead start lo", gate_lo, 4'b0000);
      repeat (DEAD - 1) @(negedge clk);
      check("R11 dead end hi", gate_hi, 4'b0000);
      check("R11 dead end lo", gate_lo, 4'b0000);
      @(negedge clk);
      check("R11 new value hi", gate_hi, 4'b1111);
      check("R11 new value lo", gate_lo, 4'b0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset hi", gate_hi, 4'b0000);
      check("R1 reset lo", gate_lo, 4'b1111);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset hi", gate_hi, 4'b0000);
      check("R1 after reset lo", gate_lo, 4'b1111);

      drive(3'd0, 0, 2'b01, 2'b01, 1, 1, 1, 4'b0000, "R2 level0");
      drive(3'd1, 0, 2'b01, 2'b01, 1, 1, 1, 4'b1010, "R3 lvl1 both low");
      drive(3'd1, 0, 2'b00, 2'b10, 1, 1, 1, 4'b0001, "R3 lvl1 c2 high");
      drive(3'd1, 0, 2'b10, 2'b01, 1, 1, 1, 4'b0110, "R7 lvl1 best score");
      drive(3'd1, 0, 2'b00, 2'b00, 1, 1, 1, 4'b0110, "R8 keep tied current");
      drive(3'd0, 0, 2'b00, 2'b00, 1, 1, 1, 4'b0000, "R2 level0 again");
      drive(3'd1, 0, 2'b00, 2'b00, 1, 1, 1, 4'b0001, "R7 tie lowest index");
      drive(3'd1, 0, 2'b01, 2'b01, 0, 1, 1, 4'b0110, "R9 c1 disabled");
      drive(3'd2, 0, 2'b01, 2'b00, 1, 1, 1, 4'b1000, "R4 lvl2 c1 low");
      drive(3'd2, 0, 2'b10, 2'b00, 1, 1, 1, 4'b0100, "R4 lvl2 c1 high");
      drive(3'd2, 1, 2'b10, 2'b00, 1, 1, 1, 4'b1000, "R6 lvl2 negative");
      drive(3'd3, 0, 2'b10, 2'b10, 1, 1, 1, 4'b0101, "R5 lvl3 both high");
      drive(3'd3, 1, 2'b10, 2'b10, 1, 1, 1, 4'b1110, "R6 lvl3 negative");
      drive(3'd3, 0, 2'b01, 2'b10, 1, 1, 1, 4'b1001, "R5 lvl3 c1 low");
      drive(3'd3, 0, 2'b00, 2'b01, 1, 1, 1, 4'b1110, "R5 lvl3 c2 low");
      drive(3'd3, 0, 2'b10, 2'b10, 0, 0, 1, 4'b1110, "R9 both disabled");
      drive(3'd6, 0, 2'b00, 2'b00, 1, 1, 1, 4'b1110, "R12 illegal level");
      drive(3'd4, 0, 2'b00, 2'b00, 1, 1, 0, 4'b1110, "R10 no strobe");
      drive(3'd4, 0, 2'b01, 2'b10, 1, 1, 1, 4'b1111, "R2 level4");
      drive(3'd0, 0, 2'b00, 2'b00, 1, 1, 1, 4'b0000, "R2 back to zero");
      wait (q.size() == 0);
      repeat (2) @(negedge clk);
      dead_probe();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule